// File: doc/BRIEF.md
# Serial Buffer Window Port

This block is the CPU-facing access port of a small three-segment buffer memory inside a queued serial controller. The CPU never addresses the buffer directly. It sees two registers: a 6-bit address pointer and a 16-bit data window. Each CPU access through the data window reaches the entry the pointer selects, and the pointer then advances by one. A run of accesses therefore streams through the buffer without software touching the pointer again.

The pointer space is split into four 16-entry ranges: transmit words, receive words, command bytes, and a reserved range. The serial engine has its own ports beside the CPU path. It reads transmit words and command bytes at indices it chooses, and it writes receive words. It has no way to change transmit or command storage. Each command byte holds a chip-select nibble (low) and a transfer-command nibble (high). This block keeps both as opaque data.

A small controller sequences CPU reads. It has two states. In ST_IDLE, pointer accesses and data-window writes finish in the same cycle. A data-window read moves the controller from ST_IDLE to ST_RD_WAIT and captures the selected entry. ST_RD_WAIT returns the captured word with ready high, advances the pointer, and always goes back to ST_IDLE. Every other condition keeps the controller in ST_IDLE.

Top module: `qbw_window`

## Requirements
- R1: Reset clears the pointer to 0x00 and puts the controller in ST_IDLE. While no CPU access is in progress, `cpu_ready` is low.
- R2: A pointer-register write (`cpu_win`=0) loads `cpu_wdata[5:0]` into the pointer and ignores bits 15:6. A pointer-register read returns the pointer in bits 5:0 with bits 15:6 zero. Both complete with `cpu_ready` high in the same cycle.
- R3: A data-window write (`cpu_win`=1) has `cpu_ready` high in the same cycle. It stores the word in the selected entry at that clock edge and increments the pointer.
- R4: A data-window read has `cpu_ready` low in its first cycle. In the second cycle `cpu_ready` is high and `cpu_rdata` holds the entry. The pointer increments at the end of that second cycle.
- R5: Pointer bits 5:4 pick the segment: 00 transmit, 01 receive, 10 command, 11 reserved. Bits 3:0 pick the entry.
- R6: In the command range, a write stores only `cpu_wdata[15:8]`. A read returns that byte in bits 15:8 with bits 7:0 zero.
- R7: In the reserved range, writes are discarded and reads return zero. The pointer still increments.
- R8: The pointer wraps from 0x3F to 0x00 on increment, for both reads and writes.
- R9: `eng_tx_data` shows transmit entry `eng_tx_idx` and `eng_cmd_data` shows command entry `eng_cmd_idx`, combinationally. The engine has no write path into either segment.
- R10: `eng_wr_en` stores `eng_wr_data` into receive entry `eng_wr_idx`. If a CPU write hits the same receive entry in the same cycle, the engine value is kept. If the two writes hit different entries, both are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | CPU access request, held until `cpu_ready` |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_win | input | 1 | 1 = data window, 0 = pointer register |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data, valid when `cpu_ready` is high |
| cpu_ready | output | 1 | Access completes this cycle |
| eng_tx_idx | input | 4 | Engine transmit read index |
| eng_tx_data | output | 16 | Transmit entry at `eng_tx_idx` |
| eng_cmd_idx | input | 4 | Engine command read index |
| eng_cmd_data | output | 8 | Command byte at `eng_cmd_idx` |
| eng_wr_en | input | 1 | Engine receive write strobe |
| eng_wr_idx | input | 4 | Engine receive write index |
| eng_wr_data | input | 16 | Engine receive write data |

## Verification
A CPU data-window write and an engine receive write can land in the same clock edge. The bench provokes this twice with the pointer in the receive range: once with both writes aimed at one entry, and once with them aimed at neighbouring entries. Each case is judged by reading the entries back through the data window. The result must show the engine's value on a shared entry and both values on distinct entries. Each cycle, the engine read ports are also compared with the bench's model while CPU writes land in the same segments.

// File: rtl/qbw_pkg.sv
package qbw_pkg;

    // Segment selected by the top two pointer bits.
    typedef enum logic [1:0] {
        SEG_TX  = 2'b00,
        SEG_RX  = 2'b01,
        SEG_CMD = 2'b10,
        SEG_RSV = 2'b11
    } seg_e;

    // CPU access sequencer states.
    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_RD_WAIT = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/qbw_store.sv
// Flop-based segment storage with N_WR write ports and N_RD read ports.
// When several write ports hit one entry, the highest port index wins.
module qbw_store #(
    parameter int W     = 16,
    parameter int IDX_W = 4,
    parameter int N_WR  = 1,
    parameter int N_RD  = 1
) (
    input  logic                        clk,
    input  logic [N_WR-1:0]             we,
    input  logic [N_WR-1:0][IDX_W-1:0]  widx,
    input  logic [N_WR-1:0][W-1:0]      wdata,
    input  logic [N_RD-1:0][IDX_W-1:0]  rd_idx,
    output logic [N_RD-1:0][W-1:0]      rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int p = 0; p < N_WR; p++) begin
            if (we[p]) begin
                mem[widx[p]] <= wdata[p];
            end
        end
    end

    for (genvar g = 0; g < N_RD; g++) begin : g_rd
        assign rd_data[g] = mem[rd_idx[g]];
    end

endmodule

// File: rtl/qbw_ptr.sv
// Address pointer: load from the CPU, or increment with natural wrap.
module qbw_ptr #(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             inc,
    output logic [PTR_W-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (inc) begin
            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/qbw_ctrl.sv
// CPU access sequencer: zero-wait writes and pointer reads,
// one wait state for data-window reads.
module qbw_ctrl
    import qbw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_sel,
    input  logic cpu_wr,
    input  logic cpu_win,
    output logic cpu_ready,
    output logic ptr_load,
    output logic ptr_inc,
    output logic data_wr,
    output logic rd_capture,
    output logic rd_wait
);
    ctl_state_e st_q;
    ctl_state_e st_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (cpu_sel && !cpu_wr && cpu_win) begin
                    st_d = ST_RD_WAIT;
                end
            end
            ST_RD_WAIT: begin
                st_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        cpu_ready  = 1'b0;
        ptr_load   = 1'b0;
        ptr_inc    = 1'b0;
        data_wr    = 1'b0;
        rd_capture = 1'b0;
        rd_wait    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (cpu_sel) begin
                    if (cpu_wr) begin
                        cpu_ready = 1'b1;
                        if (cpu_win) begin
                            data_wr = 1'b1;
                            ptr_inc = 1'b1;
                        end else begin
                            ptr_load = 1'b1;
                        end
                    end else if (cpu_win) begin
                        rd_capture = 1'b1;
                    end else begin
                        cpu_ready = 1'b1;
                    end
                end
            end
            ST_RD_WAIT: begin
                cpu_ready = 1'b1;
                ptr_inc   = 1'b1;
                rd_wait   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/qbw_window.sv
// Pointer/data-window access port to a three-segment serial buffer.
module qbw_window
    import qbw_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4,
    parameter int CMD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic              cpu_win,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    input  logic [IDX_W-1:0]  eng_tx_idx,
    output logic [DATA_W-1:0] eng_tx_data,
    input  logic [IDX_W-1:0]  eng_cmd_idx,
    output logic [CMD_W-1:0]  eng_cmd_data,
    input  logic              eng_wr_en,
    input  logic [IDX_W-1:0]  eng_wr_idx,
    input  logic [DATA_W-1:0] eng_wr_data
);
    localparam int PTR_W = IDX_W + 2;

    logic [PTR_W-1:0] ptr_q;
    logic [IDX_W-1:0] ptr_idx;
    seg_e             cur_seg;

    logic ptr_load, ptr_inc, data_wr, rd_capture, rd_wait;

    logic tx_we, rx_cpu_we, cmd_we;
    logic [1:0][DATA_W-1:0] tx_rd;
    logic [1:0][CMD_W-1:0]  cmd_rd;
    logic [DATA_W-1:0]      rx_rd;
    logic [DATA_W-1:0]      rd_value;
    logic [DATA_W-1:0]      data_q;

    assign ptr_idx = ptr_q[IDX_W-1:0];
    assign cur_seg = seg_e'(ptr_q[PTR_W-1 -: 2]);

    qbw_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_sel    (cpu_sel),
        .cpu_wr     (cpu_wr),
        .cpu_win    (cpu_win),
        .cpu_ready  (cpu_ready),
        .ptr_load   (ptr_load),
        .ptr_inc    (ptr_inc),
        .data_wr    (data_wr),
        .rd_capture (rd_capture),
        .rd_wait    (rd_wait)
    );

    qbw_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (cpu_wdata[PTR_W-1:0]),
        .inc      (ptr_inc),
        .ptr      (ptr_q)
    );

    // Segment write decode; reserved range has no storage.
    assign tx_we     = data_wr && (cur_seg == SEG_TX);
    assign rx_cpu_we = data_wr && (cur_seg == SEG_RX);
    assign cmd_we    = data_wr && (cur_seg == SEG_CMD);

    // Transmit: CPU writes; read port 0 for CPU, port 1 for engine.
    qbw_store #(.W(DATA_W), .IDX_W(IDX_W), .N_WR(1), .N_RD(2)) u_tx (
        .clk     (clk),
        .we      (tx_we),
        .widx    (ptr_idx),
        .wdata   (cpu_wdata),
        .rd_idx  ({eng_tx_idx, ptr_idx}),
        .rd_data (tx_rd)
    );

    // Receive: port 0 CPU, port 1 engine (engine wins on the same entry).
    qbw_store #(.W(DATA_W), .IDX_W(IDX_W), .N_WR(2), .N_RD(1)) u_rx (
        .clk     (clk),
        .we      ({eng_wr_en, rx_cpu_we}),
        .widx    ({eng_wr_idx, ptr_idx}),
        .wdata   ({eng_wr_data, cpu_wdata}),
        .rd_idx  (ptr_idx),
        .rd_data (rx_rd)
    );

    // Command: upper byte of the window only; engine read-only.
    qbw_store #(.W(CMD_W), .IDX_W(IDX_W), .N_WR(1), .N_RD(2)) u_cmd (
        .clk     (clk),
        .we      (cmd_we),
        .widx    (ptr_idx),
        .wdata   (cpu_wdata[DATA_W-1 -: CMD_W]),
        .rd_idx  ({eng_cmd_idx, ptr_idx}),
        .rd_data (cmd_rd)
    );

    assign eng_tx_data  = tx_rd[1];
    assign eng_cmd_data = cmd_rd[1];

    always_comb begin
        unique case (cur_seg)
            SEG_TX:  rd_value = tx_rd[0];
            SEG_RX:  rd_value = rx_rd;
            SEG_CMD: rd_value = {cmd_rd[0], {(DATA_W-CMD_W){1'b0}}};
            SEG_RSV: rd_value = '0;
        endcase
    end

    // Read capture during the wait state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_capture) begin
            data_q <= rd_value;
        end
    end

    assign cpu_rdata = rd_wait ? data_q
                               : {{(DATA_W-PTR_W){1'b0}}, ptr_q};

endmodule

// File: rtl/qbw_window_chk.sv
module qbw_window_chk #(
    parameter int PTR_W  = 6,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_sel,
    input logic              cpu_wr,
    input logic              cpu_win,
    input logic              cpu_ready,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic [PTR_W-1:0]  ptr_wval,
    input logic [PTR_W-1:0]  ptr,
    input logic              rd_wait
);
    // R3
    write_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && cpu_wr) |-> cpu_ready);

    // R4
    read_first_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && !cpu_wr && cpu_win && !rd_wait) |-> !cpu_ready);

    // R4
    read_second_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_wait |-> cpu_ready);

    // R3
    write_ptr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && cpu_wr && cpu_win) |=> (ptr == $past(ptr) + 1'b1));

    // R4
    read_ptr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_wait |=> (ptr == $past(ptr) + 1'b1));

    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && cpu_wr && !cpu_win) |=> (ptr == $past(ptr_wval)));

    // R2
    ptr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && !cpu_wr && !cpu_win && !rd_wait) |->
            (cpu_ready && cpu_rdata[DATA_W-1:PTR_W] == '0));

    // R6
    cmd_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_wait && ptr[PTR_W-1 -: 2] == 2'b10) |-> (cpu_rdata[7:0] == 8'h00));

    // R7
    rsv_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_wait && ptr[PTR_W-1 -: 2] == 2'b11) |-> (cpu_rdata == '0));

    // R1
    idle_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_sel && !rd_wait) |=> $stable(ptr));

    // R1
    idle_ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_sel && !rd_wait) |-> !cpu_ready);

endmodule

bind qbw_window qbw_window_chk #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_sel   (cpu_sel),
    .cpu_wr    (cpu_wr),
    .cpu_win   (cpu_win),
    .cpu_ready (cpu_ready),
    .cpu_rdata (cpu_rdata),
    .ptr_wval  (cpu_wdata[PTR_W-1:0]),
    .ptr       (ptr_q),
    .rd_wait   (rd_wait)
);

// File: tb/qbw_window_bench.sv
module qbw_window_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_sel = 1'b0, cpu_wr = 1'b0, cpu_win = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ready;
    logic [3:0]  eng_tx_idx = '0, eng_cmd_idx = '0;
    logic [15:0] eng_tx_data;
    logic [7:0]  eng_cmd_data;
    logic        eng_wr_en = 1'b0;
    logic [3:0]  eng_wr_idx = '0;
    logic [15:0] eng_wr_data = '0;

    always #(CLK_P/2) clk = ~clk;

    qbw_window u_qbw_window (
        .clk(clk), .rst_n(rst_n),
        .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_win(cpu_win),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .eng_tx_idx(eng_tx_idx), .eng_tx_data(eng_tx_data),
        .eng_cmd_idx(eng_cmd_idx), .eng_cmd_data(eng_cmd_data),
        .eng_wr_en(eng_wr_en), .eng_wr_idx(eng_wr_idx), .eng_wr_data(eng_wr_data)
    );

    // Behavioural reference model
    int ptr_m = 0;
    int tx_m [16];
    int rx_m [16];
    int cmd_m [16];
    bit tx_k [16];
    bit cmd_k [16];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %h exp %h", what, act, exp);
        end
    endtask

    function automatic int model_read();
        int idx = ptr_m & 15;
        case (ptr_m >> 4)
            0: return tx_m[idx];
            1: return rx_m[idx];
            2: return (cmd_m[idx] << 8) & 16'hFFFF;
            default: return 0;
        endcase
    endfunction

    task automatic model_store(input int v);
        int idx = ptr_m & 15;
        case (ptr_m >> 4)
            0: begin tx_m[idx] = v & 16'hFFFF; tx_k[idx] = 1; end
            1: rx_m[idx] = v & 16'hFFFF;
            2: begin cmd_m[idx] = (v >> 8) & 8'hFF; cmd_k[idx] = 1; end
            default: ;
        endcase
        ptr_m = (ptr_m + 1) & 63;
    endtask

    task automatic drive(input bit sel, input bit wr, input bit win, input logic [15:0] wd);
        @(negedge clk);
        cpu_sel = sel; cpu_wr = wr; cpu_win = win; cpu_wdata = wd;
        eng_wr_en = 1'b0;
        eng_tx_idx = 4'(ptr_m);
        eng_cmd_idx = 4'(ptr_m + 3);
    endtask

    task automatic bus_idle(input string tag);
        @(negedge clk);
        cpu_sel = 1'b0; eng_wr_en = 1'b0;
        #1 chk(cpu_ready == 1'b0, {tag, " ready low when idle"}, int'(cpu_ready), 0);
    endtask

    task automatic ptr_write(input logic [15:0] v);
        drive(1, 1, 0, v);
        #1 chk(cpu_ready == 1'b1, "R2 pointer write ready", int'(cpu_ready), 1);
        @(posedge clk);
        ptr_m = int'(v) & 63;
    endtask

    task automatic ptr_read(input string tag);
        drive(1, 0, 0, 16'h0);
        #1 chk(cpu_ready == 1'b1, {tag, " pointer read ready"}, int'(cpu_ready), 1);
        chk(cpu_rdata == 16'(ptr_m), {tag, " pointer read value"}, int'(cpu_rdata), ptr_m);
        @(posedge clk);
    endtask

    task automatic data_write(input logic [15:0] v, input string tag);
        drive(1, 1, 1, v);
        #1 chk(cpu_ready == 1'b1, {tag, " window write ready"}, int'(cpu_ready), 1);
        @(posedge clk);
        model_store(int'(v));
    endtask

    task automatic data_read(input string tag);
        int exp;
        drive(1, 0, 1, 16'h0);
        #1 chk(cpu_ready == 1'b0, "R4 read wait state", int'(cpu_ready), 0);
        @(negedge clk);
        exp = model_read();
        #1 chk(cpu_ready == 1'b1, "R4 read ready second cycle", int'(cpu_ready), 1);
        chk(cpu_rdata == 16'(exp), {tag, " window read value"}, int'(cpu_rdata), exp);
        @(posedge clk);
        ptr_m = (ptr_m + 1) & 63;
    endtask

    task automatic eng_write(input logic [3:0] idx, input logic [15:0] v);
        @(negedge clk);
        cpu_sel = 1'b0;
        eng_wr_en = 1'b1; eng_wr_idx = idx; eng_wr_data = v;
        @(posedge clk);
        rx_m[idx] = int'(v);
    endtask

    task automatic collide(input logic [15:0] cv, input logic [3:0] eidx, input logic [15:0] ev);
        drive(1, 1, 1, cv);
        eng_wr_en = 1'b1; eng_wr_idx = eidx; eng_wr_data = ev;
        #1 chk(cpu_ready == 1'b1, "R10 write ready during engine write", int'(cpu_ready), 1);
        @(posedge clk);
        model_store(int'(cv));
        rx_m[eidx] = int'(ev);
    endtask

    // Engine read ports compared with the model on every clock (R9)
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            if (tx_k[eng_tx_idx])
                chk(eng_tx_data == 16'(tx_m[eng_tx_idx]), "R9 engine transmit port",
                    int'(eng_tx_data), tx_m[eng_tx_idx]);
            if (cmd_k[eng_cmd_idx])
                chk(eng_cmd_data == 8'(cmd_m[eng_cmd_idx]), "R9 engine command port",
                    int'(eng_cmd_data), cmd_m[eng_cmd_idx]);
        end
    end

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_idle("R1");
        ptr_read("R1");

        // R2: reserved pointer bits ignored
        ptr_write(16'hFFC5);
        ptr_read("R2");
        ptr_write(16'h0000);

        // R3: back-to-back transmit burst from 0x00, then R5 boundary
        for (int i = 0; i < 16; i++) data_write(16'hA000 + 16'(i * 16'h0111), "R3");
        ptr_read("R5");
        bus_idle("R1");

        // R4: read back the transmit segment from 0x00
        ptr_write(16'h0000);
        for (int i = 0; i < 16; i++) data_read("R4");
        bus_idle("R1");

        // R6: command range upper-byte use
        ptr_write(16'h0020);
        for (int i = 0; i < 4; i++) data_write(16'h5AC3 ^ 16'(i * 16'h1111), "R6");
        ptr_read("R6");
        ptr_write(16'h0020);
        for (int i = 0; i < 4; i++) data_read("R6");

        // R5: segment boundary 0x2F -> 0x30
        ptr_write(16'h002F);
        data_write(16'h9E00, "R5");
        ptr_read("R5");

        // R7: reserved range
        ptr_write(16'h0030);
        data_write(16'h1234, "R7");
        ptr_read("R7");
        ptr_write(16'h0030);
        data_read("R7");
        ptr_write(16'h0000);
        data_read("R7 transmit entry untouched");

        // R8: wrap on write and on read
        ptr_write(16'h003F);
        data_write(16'h7777, "R8");
        ptr_read("R8");
        ptr_write(16'h003F);
        data_read("R8");
        ptr_read("R8");

        // R10: engine receive writes and collisions
        eng_write(4'd3, 16'hBEEF);
        ptr_write(16'h0013);
        data_read("R10 engine write");
        ptr_write(16'h0015);
        collide(16'h1111, 4'd5, 16'h2222);
        ptr_write(16'h0015);
        data_read("R10 same-entry engine priority");
        ptr_write(16'h0016);
        collide(16'h3333, 4'd7, 16'h4444);
        ptr_write(16'h0016);
        data_read("R10 distinct cpu entry");
        data_read("R10 distinct engine entry");
        bus_idle("R1");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule